// File: doc/BRIEF.md
# Board System Control Register Bank

A bus-slave bank of board control and identification registers in a 4 KB window, reached through a 32-bit word-access bus. Its transfers take a setup cycle and an access cycle, and the slave never inserts wait states. A build-time variant parameter selects which configuration slots exist. Slots that are absent behave like holes in the map: they read zero, ignore writes and flag an error.

The bank drives two kinds of side-effect outputs. Bit 0 of the first control word drives a remap line. The low bits of the second control word drive a row of LEDs. Neither output is driven in variant C, where both are held low. The bank also holds a clock-lock register in which only the mask byte can be written. It exposes three read-only words whose values are fixed when the block is built.

Top module: `sys_ctrl_bank`

## Requirements
- R1: Word offsets: configuration slot k (k = 0..7) at 4*k, clock-lock register at 0x100, auxiliary ID at 0xFF8, main ID at 0xFFC. The address is 12 bits and must be word aligned. Every other address, including any address whose bits [1:0] are non-zero, is unmapped.
- R2: Slot presence by variant (encoding VAR_A=0, VAR_B=1, VAR_C=2, VAR_PLAIN=3). Slots 2 and 5 exist in A, B and C. Slot 3 exists only in PLAIN. Slot 6 exists in A and C. Slot 7 exists only in C. Slots 0, 1 and 4 exist in every variant.
- R3: An access to an absent slot or an unmapped offset returns zero. It raises pslverr_o for that access cycle only, and a write to it changes no state.
- R4: Slot 3, where present, always reads zero and raises no error.
- R5: Slot 4, the auxiliary ID and the main ID read their build-time parameter values. Writes to them are ignored without error.
- R6: Slot 0 resets to the CFG0_RST parameter and reads back all 32 written bits. Outside variant C, remap_o equals its bit 0. In variant C, remap_o stays 0.
- R7: Slot 1 resets to 0 and reads back all 32 written bits. Outside variant C, led_o[i] equals its bit i for i < NUM_LEDS. In variant C, led_o stays 0.
- R8: The clock-lock register resets to 0xFFFF0001. A write changes only bits [31:24]. Bits [23:16] read as all ones, bit 0 reads as 1, and the rest read as 0.
- R9: Slots 2, 5, 6 and 7, where present, reset to 0 and read back what was written. Slot 7 has its own storage, and a write to slot 7 leaves slot 6 unchanged.
- R10: pready_o is always 1. A write lands at the clock edge that ends its access cycle. Read data is valid during the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access cycle |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Error for an access to an absent or unmapped offset |
| remap_o | output | 1 | Remap control from slot 0 bit 0 |
| led_o | output | NUM_LEDS | LED drive from the low bits of slot 1 |

## Verification
On every cycle the assertions check four things. The decoder selects at most one register. The error flag appears only in an access cycle, and only with zero read data. The remap line follows each slot 0 write, and the LEDs hold still without a slot 1 write. A clock-lock write moves only the mask byte, and a slot 7 write leaves slot 6 alone. Some behaviours only the bench scenarios can show: the per-variant presence map, the parameter reset values, the silent discard of writes to read-only and absent slots, and the masking of the LED row to NUM_LEDS bits. The bench shows these by comparing two builds, variant C and the plain variant.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  typedef enum logic [1:0] {VAR_A = 2'd0, VAR_B = 2'd1, VAR_C = 2'd2, VAR_PLAIN = 2'd3} variant_e;

  localparam int NUM_CFG  = 8;
  localparam int IDX_DLL  = 8;
  localparam int IDX_AUX  = 9;
  localparam int IDX_ID   = 10;
  localparam int NUM_REGS = 11;
  localparam int AW       = 12;
  localparam logic [31:0] DLL_RST = 32'hFFFF_0001;

  function automatic logic [AW-1:0] reg_offset(int i);
    if (i < NUM_CFG) return AW'(i * 4);
    else if (i == IDX_DLL) return 12'h100;
    else if (i == IDX_AUX) return 12'hFF8;
    else return 12'hFFC;
  endfunction

  function automatic bit reg_present(variant_e v, int i);
    case (i)
      2, 5:    return v != VAR_PLAIN;
      3:       return v == VAR_PLAIN;
      6:       return (v == VAR_A) || (v == VAR_C);
      7:       return v == VAR_C;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
#(
  parameter variant_e VARIANT = VAR_PLAIN
) (
  input  logic [AW-1:0]       addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    if (reg_present(VARIANT, i)) begin : g_on
      assign sel_o[i] = (addr_i == reg_offset(i));
    end else begin : g_off
      assign sel_o[i] = 1'b0;
    end
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
#(
  parameter variant_e    VARIANT  = VAR_PLAIN,
  parameter int          NUM_LEDS = 8,
  parameter logic [31:0] CFG0_RST = 32'h0,
  parameter logic [31:0] CFG4_VAL = 32'h0,
  parameter logic [31:0] AUX_ID   = 32'h0,
  parameter logic [31:0] MAIN_ID  = 32'h0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [NUM_REGS-1:0]       sel_i,
  input  logic [31:0]               wdata_i,
  output logic [NUM_REGS-1:0][31:0] words_o,
  output logic                      remap_o,
  output logic [NUM_LEDS-1:0]       led_o
);
  localparam bit DRIVE_OUTS = (VARIANT != VAR_C);

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    if (i == 3) begin : g_zero
      assign words_o[i] = '0;
    end else if (i == 4) begin : g_ro
      assign words_o[i] = CFG4_VAL;
    end else if (reg_present(VARIANT, i)) begin : g_rw
      localparam logic [31:0] RST = (i == 0) ? CFG0_RST : 32'h0;
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST;
        else if (wr_en_i && sel_i[i]) q <= wdata_i;
      end
      assign words_o[i] = q;
    end else begin : g_absent
      assign words_o[i] = '0;
    end
  end

  // only the mask byte is stored; lock status is always reported locked
  logic [7:0] dll_mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dll_mask_q <= DLL_RST[31:24];
    else if (wr_en_i && sel_i[IDX_DLL]) dll_mask_q <= wdata_i[31:24];
  end
  assign words_o[IDX_DLL] = {dll_mask_q, DLL_RST[23:0]};
  assign words_o[IDX_AUX] = AUX_ID;
  assign words_o[IDX_ID]  = MAIN_ID;

  if (DRIVE_OUTS) begin : g_outs
    assign remap_o = words_o[0][0];
    assign led_o   = words_o[1][NUM_LEDS-1:0];
  end else begin : g_no_outs
    assign remap_o = 1'b0;
    assign led_o   = '0;
  end

  assert_dll_mask_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[IDX_DLL]) |=>
      (words_o[IDX_DLL][31:24] == $past(wdata_i[31:24])) &&
      (words_o[IDX_DLL][23:0] == $past(words_o[IDX_DLL][23:0])));

  assert_led_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i[1]) |=> $stable(led_o));

  if (DRIVE_OUTS) begin : g_chk_remap
    assert_remap_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_i[0]) |=> (remap_o == $past(wdata_i[0])));
  end

  if (VARIANT == VAR_C) begin : g_chk_c7
    assert_cfg7_isolated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_i[7]) |=> $stable(words_o[6]));
  end
endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
  import sys_ctrl_pkg::*;
#(
  parameter variant_e    VARIANT  = VAR_PLAIN,
  parameter int          NUM_LEDS = 8,
  parameter logic [31:0] CFG0_RST = 32'h0,
  parameter logic [31:0] CFG4_VAL = 32'h0,
  parameter logic [31:0] AUX_ID   = 32'h0,
  parameter logic [31:0] MAIN_ID  = 32'h0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [11:0]         paddr_i,
  input  logic [31:0]         pwdata_i,
  output logic [31:0]         prdata_o,
  output logic                pready_o,
  output logic                pslverr_o,
  output logic                remap_o,
  output logic [NUM_LEDS-1:0] led_o
);
  logic                      access;
  logic [NUM_REGS-1:0]       sel;
  logic                      hit;
  logic [NUM_REGS-1:0][31:0] words;
  logic [31:0]               mux;

  assign access = psel_i && penable_i;

  sys_ctrl_decode #(.VARIANT(VARIANT)) u_dec (
    .addr_i (paddr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  sys_ctrl_regs #(
    .VARIANT (VARIANT), .NUM_LEDS(NUM_LEDS), .CFG0_RST(CFG0_RST),
    .CFG4_VAL(CFG4_VAL), .AUX_ID(AUX_ID), .MAIN_ID(MAIN_ID)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (access && pwrite_i),
    .sel_i   (sel),
    .wdata_i (pwdata_i),
    .words_o (words),
    .remap_o (remap_o),
    .led_o   (led_o)
  );

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_REGS; i++) if (sel[i]) mux |= words[i];
  end

  assign prdata_o  = access ? mux : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = access && !hit;

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  assert_err_in_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (psel_i && penable_i));

  assert_err_zero_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (prdata_o == 32'h0));

  assert_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o);
endmodule

// File: tb/sim_sys_ctrl_bank.sv
module sim_sys_ctrl_bank;
  import sys_ctrl_pkg::*;

  localparam logic [31:0] C4  = 32'h0000_00C4;
  localparam logic [31:0] AID = 32'hA1D0_0042;
  localparam logic [31:0] MID = 32'h4105_5240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic psel0 = 0, psel1 = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] rd0, rd1;
  logic rdy0, rdy1, err0, err1, remap0, remap1;
  logic [3:0] led0;
  logic [7:0] led1;

  sys_ctrl_bank #(.VARIANT(VAR_C), .NUM_LEDS(4), .CFG0_RST(32'h3),
    .CFG4_VAL(C4), .AUX_ID(AID), .MAIN_ID(MID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel0), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd0),
    .pready_o(rdy0), .pslverr_o(err0), .remap_o(remap0), .led_o(led0));

  sys_ctrl_bank #(.VARIANT(VAR_PLAIN), .NUM_LEDS(8), .CFG0_RST(32'h1),
    .CFG4_VAL(C4), .AUX_ID(AID), .MAIN_ID(MID)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel1), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd1),
    .pready_o(rdy1), .pslverr_o(err1), .remap_o(remap1), .led_o(led1));

  typedef struct {
    bit          dut;
    bit          chk_data;
    logic [31:0] data;
    bit          err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: setup cycle, access cycle, idle; expected response queued
  task automatic xfer(bit dut, bit wr, logic [11:0] a, logic [31:0] d,
                      bit chk_data, logic [31:0] exp, bit exp_err, string tag);
    exp_t e;
    @(negedge clk);
    psel0 = (dut == 0); psel1 = (dut == 1);
    pwrite = wr; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    e.dut = dut; e.chk_data = chk_data; e.data = exp; e.err = exp_err; e.tag = tag;
    exp_q.push_back(e);
    penable = 1;
    @(negedge clk);
    psel0 = 0; psel1 = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(bit dut, logic [11:0] a, logic [31:0] exp, bit exp_err, string tag);
    xfer(dut, 1'b0, a, 32'h0, 1'b1, exp, exp_err, tag);
  endtask

  task automatic wr(bit dut, logic [11:0] a, logic [31:0] d, bit exp_err, string tag);
    xfer(dut, 1'b1, a, d, 1'b0, 32'h0, exp_err, tag);
  endtask

  // monitor: compares each access cycle against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (penable && (psel0 || psel1)) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          total++; fails++;
          $display("FAIL R10 unexpected access act=1 exp=0");
        end else begin
          e = exp_q.pop_front();
          chk({e.tag, " R10 ready"}, {31'h0, e.dut ? rdy1 : rdy0}, 32'h1);
          chk({e.tag, " err"}, {31'h0, e.dut ? err1 : err0}, {31'h0, e.err});
          if (e.chk_data) chk({e.tag, " data"}, e.dut ? rd1 : rd0, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R6 reset remap plain", {31'h0, remap1}, 32'h1);
    chk("R6 reset remap varC", {31'h0, remap0}, 32'h0);
    chk("R7 reset leds plain", {24'h0, led1}, 32'h0);
    rd(1, 12'h000, 32'h1, 0, "R6 cfg0 reset");
    rd(1, 12'h004, 32'h0, 0, "R7 cfg1 reset");
    rd(1, 12'h100, 32'hFFFF_0001, 0, "R8 dll reset");
    rd(0, 12'h000, 32'h3, 0, "R6 cfg0 reset varC");
    rd(0, 12'h008, 32'h0, 0, "R9 cfg2 reset");
    rd(0, 12'h014, 32'h0, 0, "R9 cfg5 reset");
    rd(0, 12'h018, 32'h0, 0, "R9 cfg6 reset");
    rd(0, 12'h01C, 32'h0, 0, "R9 cfg7 reset");

    // plain variant presence map
    rd(1, 12'h00C, 32'h0, 0, "R4 cfg3 reads zero");
    wr(1, 12'h00C, 32'hFFFF_FFFF, 0, "R4 cfg3 write");
    rd(1, 12'h00C, 32'h0, 0, "R4 cfg3 after write");
    rd(1, 12'h008, 32'h0, 1, "R2 cfg2 absent plain");
    wr(1, 12'h014, 32'h5555, 1, "R3 cfg5 write absent");
    rd(1, 12'h014, 32'h0, 1, "R3 cfg5 still zero");
    rd(1, 12'h018, 32'h0, 1, "R2 cfg6 absent plain");
    rd(1, 12'h01C, 32'h0, 1, "R2 cfg7 absent plain");

    // LEDs and remap
    wr(1, 12'h004, 32'h0000_00A5, 0, "R7 cfg1 write");
    chk("R7 leds A5", {24'h0, led1}, 32'hA5);
    rd(1, 12'h004, 32'hA5, 0, "R7 cfg1 readback");
    wr(1, 12'h004, 32'hDEAD_015A, 0, "R7 cfg1 wide write");
    chk("R7 leds masked", {24'h0, led1}, 32'h5A);
    rd(1, 12'h004, 32'hDEAD_015A, 0, "R7 cfg1 full readback");
    wr(1, 12'h000, 32'hFFFF_FFFE, 0, "R6 cfg0 write");
    chk("R6 remap low", {31'h0, remap1}, 32'h0);
    rd(1, 12'h000, 32'hFFFF_FFFE, 0, "R6 cfg0 readback");
    wr(1, 12'h000, 32'h1, 0, "R6 cfg0 write1");
    chk("R6 remap high", {31'h0, remap1}, 32'h1);

    // DLL mask
    wr(1, 12'h100, 32'h1234_5678, 0, "R8 dll write");
    rd(1, 12'h100, 32'h12FF_0001, 0, "R8 dll mask only");
    wr(1, 12'h100, 32'h0000_0000, 0, "R8 dll clear");
    rd(1, 12'h100, 32'h00FF_0001, 0, "R8 dll lock bits kept");

    // read-only words
    wr(1, 12'h010, 32'h0, 0, "R5 cfg4 write");
    rd(1, 12'h010, C4, 0, "R5 cfg4 value");
    wr(1, 12'hFF8, 32'h0, 0, "R5 aux write");
    rd(1, 12'hFF8, AID, 0, "R5 aux id");
    wr(1, 12'hFFC, 32'h0, 0, "R5 main write");
    rd(1, 12'hFFC, MID, 0, "R5 main id");

    // unmapped offsets
    rd(1, 12'h020, 32'h0, 1, "R1 past cfg7");
    rd(1, 12'h0A0, 32'h0, 1, "R1 hole 0A0");
    rd(1, 12'h002, 32'h0, 1, "R1 unaligned");
    rd(1, 12'h104, 32'h0, 1, "R1 past dll");
    wr(1, 12'h0A4, 32'hFFFF_FFFF, 1, "R3 unmapped write");
    wr(1, 12'h005, 32'h0, 1, "R3 unaligned write");
    rd(1, 12'h004, 32'hDEAD_015A, 0, "R3 cfg1 untouched");
    chk("R3 leds untouched", {24'h0, led1}, 32'h5A);
    rd(1, 12'h000, 32'h1, 0, "R3 cfg0 untouched");

    // variant C
    rd(0, 12'h00C, 32'h0, 1, "R2 cfg3 absent varC");
    wr(0, 12'h018, 32'h0000_1111, 0, "R9 cfg6 write");
    wr(0, 12'h01C, 32'h0000_2222, 0, "R9 cfg7 write");
    rd(0, 12'h018, 32'h0000_1111, 0, "R9 cfg6 kept");
    rd(0, 12'h01C, 32'h0000_2222, 0, "R9 cfg7 readback");
    wr(0, 12'h008, 32'hCAFE_0002, 0, "R9 cfg2 write");
    rd(0, 12'h008, 32'hCAFE_0002, 0, "R9 cfg2 readback");
    wr(0, 12'h014, 32'h0BEE_F005, 0, "R9 cfg5 write");
    rd(0, 12'h014, 32'h0BEE_F005, 0, "R9 cfg5 readback");
    wr(0, 12'h000, 32'h1, 0, "R6 varC cfg0 write");
    chk("R6 varC remap low", {31'h0, remap0}, 32'h0);
    rd(0, 12'h000, 32'h1, 0, "R6 varC cfg0 readback");
    wr(0, 12'h004, 32'hF, 0, "R7 varC cfg1 write");
    chk("R7 varC leds low", {28'h0, led0}, 32'h0);
    rd(0, 12'h004, 32'hF, 0, "R7 varC cfg1 readback");
    rd(0, 12'h100, 32'hFFFF_0001, 0, "R8 varC dll");
    rd(0, 12'hFFC, MID, 0, "R5 varC main id");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL R10 pending act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule